// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block watches a running calendar kept in BCD by a separate timekeeping block. It raises an alarm when that calendar reaches a time stored in its own alarm registers. Six alarm bytes hold second, minute, hour, day-of-month, month and year. A single control byte holds one master enable and a compare-enable bit for each of those fields. Fields whose enable is clear are treated as "don't care". Enabling only the second field gives an alarm once a minute, seconds plus minutes gives one per hour, and so on.

Matching is checked only on the cycle the calendar's once-per-second strobe is high, so each matching second produces exactly one interrupt pulse. A sticky pending flag is set together with the pulse and stays set until software clears it through the byte-wide register port. To rearm safely, software writes the control byte to zero, loads the field values and then writes the enables again.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset every register reads 0. The register port maps address 0 to the control byte and addresses 1 to 6 to the second, minute, hour, day, month and year alarm bytes. Address 7 holds the pending flag in bit 0. A write at addresses 0 to 6 is read back unchanged on the combinational read port, except that bit 7 of the control byte always reads 0.
- R2: Control byte layout: bit 0 is the master enable. Bits 1 to 6 enable comparison of second, minute, hour, day, month and year, in that order.
- R3: A match is evaluated only in a cycle where `sec_tick` is high. `alarm_irq` is high during the cycle after that clock edge. With `sec_tick` low, no interrupt fires whatever the calendar inputs are.
- R4: A field whose enable bit is clear takes no part in the match. Every enabled field must equal its alarm byte for a match.
- R5: With the master enable clear, no interrupt fires.
- R6: With the master enable set but all six field enables clear, no interrupt fires.
- R7: `alarm_irq` is a one-cycle pulse for each matching strobe.
- R8: `alarm_pending` is set in the same cycle as `alarm_irq` and stays set until a write to address 7 with bit 0 set. If that write and a new alarm occur together, the alarm wins.
- R9: After the control byte is written to zero, a following strobe with a calendar equal to the alarm bytes produces no interrupt.
- R10: Comparison is raw byte equality of the BCD codes, across the full month range 01 to 12 and the year range 00 to 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register address |
| reg_wdata | input | DW (8) | Write data |
| reg_rdata | output | DW (8) | Combinational read data for `reg_addr` |
| sec_tick | input | 1 | One-second strobe from the timekeeper, high for one cycle |
| now_sec | input | DW (8) | Current seconds, BCD |
| now_min | input | DW (8) | Current minutes, BCD |
| now_hour | input | DW (8) | Current hours, BCD |
| now_day | input | DW (8) | Current day of month, BCD |
| now_mon | input | DW (8) | Current month, BCD |
| now_year | input | DW (8) | Current two-digit year, BCD |
| alarm_irq | output | 1 | One-cycle alarm pulse |
| alarm_pending | output | 1 | Sticky alarm flag |

## Verification
A register write takes effect at the clock edge that ends its cycle, and it is visible on the combinational read port one delta later. The bench therefore reads back one cycle after each write, a nanosecond after the falling edge. The interrupt and the pending flag come from a single register stage after the strobe edge. The bench raises `sec_tick` for one cycle, samples both outputs at the next falling edge, and checks at the falling edge after that that the pulse has dropped. Register writes are never issued in the same cycle as a strobe, so the result is never taken from a stale control byte.

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sec_tick,
  input  logic [DW-1:0] now_sec,
  input  logic [DW-1:0] now_min,
  input  logic [DW-1:0] now_hour,
  input  logic [DW-1:0] now_day,
  input  logic [DW-1:0] now_mon,
  input  logic [DW-1:0] now_year,
  output logic          alarm_irq,
  output logic          alarm_pending
);
  localparam int NF     = 6;
  localparam int CW     = NF + 1;
  localparam int STAT_A = NF + 1;

  logic [CW-1:0]          ctrl;
  logic [NF-1:0][DW-1:0]  alm;
  logic [NF-1:0][DW-1:0]  now;
  logic [NF-1:0]          hit;
  logic                   fire;
  logic                   clr;

  assign now = {now_year, now_mon, now_day, now_hour, now_min, now_sec};

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign hit[i] = !ctrl[i+1] || (alm[i] == now[i]);
  end

  assign fire = sec_tick && ctrl[0] && (|ctrl[CW-1:1]) && (&hit);
  assign clr  = reg_wr && (reg_addr == AW'(STAT_A)) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      alm  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == '0) ctrl <= reg_wdata[CW-1:0];
      for (int i = 0; i < NF; i++)
        if (reg_addr == AW'(i + 1)) alm[i] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_irq     <= 1'b0;
      alarm_pending <= 1'b0;
    end else begin
      alarm_irq     <= fire;
      alarm_pending <= fire || (alarm_pending && !clr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = DW'(ctrl);
    if (reg_addr == AW'(STAT_A)) reg_rdata = DW'(alarm_pending);
    for (int i = 0; i < NF; i++)
      if (reg_addr == AW'(i + 1)) reg_rdata = alm[i];
  end

  assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(sec_tick));
  assert_master_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(ctrl[0]));
  assert_some_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> ($past(ctrl[CW-1:1]) != '0));
  assert_pending_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_pending);
  assert_pending_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!alarm_pending || alarm_irq));
  assert_zero_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && reg_wdata == '0) |=> ##1 !alarm_irq);
endmodule

// File: tb/bcd_alarm_match_test.sv
module bcd_alarm_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sec_tick = 1'b0;
  logic [7:0] nv [6];
  logic       alarm_irq, alarm_pending;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [6:0] m_ctrl = '0;
  logic [7:0] m_alm [6];
  logic       m_pend = 1'b0;

  always #4 clk = ~clk;

  bcd_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .now_sec(nv[0]), .now_min(nv[1]), .now_hour(nv[2]), .now_day(nv[3]),
    .now_mon(nv[4]), .now_year(nv[5]),
    .alarm_irq(alarm_irq), .alarm_pending(alarm_pending));

  function automatic logic expect_hit();
    logic ok = m_ctrl[0] && (m_ctrl[6:1] != 0);
    for (int i = 0; i < 6; i++)
      if (m_ctrl[i+1] && m_alm[i] != nv[i]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [7:0] rnd_bcd(int lim);
    int v = $urandom_range(lim);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 0) m_ctrl = d[6:0];
    else if (a == 7) begin if (d[0]) m_pend = 1'b0; end
    else m_alm[a-1] = d;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic tick(string tag);
    logic e = expect_hit();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    if (e) m_pend = 1'b1;
    chk({tag, " irq"}, 8'(alarm_irq), 8'(e));
    chk("R8 pending", 8'(alarm_pending), 8'(m_pend));
    @(negedge clk);
    chk("R7 pulse width", 8'(alarm_irq), 8'h0);
  endtask

  task automatic set_now_to_alarm();
    for (int i = 0; i < 6; i++) nv[i] = m_alm[i];
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) begin nv[i] = 8'h00; m_alm[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset value");
    chk("R1 reset irq", 8'(alarm_irq), 8'h0);

    wr(1, 8'h30); wr(2, 8'h15); wr(3, 8'h07); wr(4, 8'h28); wr(5, 8'h12); wr(6, 8'h99);
    rd(1, 8'h30, "R1 sec readback"); rd(5, 8'h12, "R10 month readback");
    rd(6, 8'h99, "R10 year readback");
    wr(0, 8'hFF); rd(0, 8'h7F, "R2 ctrl readback");

    wr(0, 8'h03);
    nv[0] = 8'h30; nv[1] = 8'h44; nv[2] = 8'h21; nv[3] = 8'h02; nv[4] = 8'h03; nv[5] = 8'h10;
    tick("R4 sec only match");
    rd(7, 8'h01, "R8 pending read");
    wr(7, 8'h01); rd(7, 8'h00, "R8 pending cleared");
    nv[0] = 8'h31; tick("R4 sec mismatch");

    wr(0, 8'h7F); set_now_to_alarm(); tick("R10 full match 12/99");
    nv[5] = 8'h98; tick("R10 year differs");
    set_now_to_alarm();
    repeat (5) begin
      @(negedge clk); chk("R3 no strobe", 8'(alarm_irq), 8'h0);
    end
    wr(0, 8'h7E); tick("R5 master off");
    wr(0, 8'h01); tick("R6 no fields");
    wr(0, 8'h7F); wr(0, 8'h00); tick("R9 ctrl zeroed");
    wr(7, 8'h01);

    for (int n = 0; n < 300; n++) begin
      wr(0, 8'h00);
      wr(1, rnd_bcd(59)); wr(2, rnd_bcd(59)); wr(3, rnd_bcd(23));
      wr(4, 8'(rnd_bcd(27) + 8'h01)); wr(5, (n % 12 < 9) ? 8'(n % 12 + 1) : 8'(n % 12 + 7));
      wr(6, rnd_bcd(99));
      wr(0, {1'b0, 6'($urandom), 1'($urandom_range(3) != 0)});
      for (int i = 0; i < 6; i++)
        nv[i] = ($urandom_range(3) != 0) ? m_alm[i] : rnd_bcd(59);
      tick("R4 random");
      if ($urandom_range(1) == 1) wr(7, 8'h01);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule